// File: doc/BRIEF.md
# Three-Channel Programmable Interval Timer

This block sits on a narrow byte-wide register bus and provides three independent 16-bit down counters. Each channel has its own clock-enable, gate input and output pin. Software configures a channel by writing one byte to a shared control port. The upper bits of that byte pick the channel. The remaining fields give the byte access style, the counting mode and a binary/decimal flag. Counts are then loaded through the channel's own data port, one byte per write.

A running count can be frozen by a snapshot command issued on the control port. Software then reads the frozen value byte by byte while the counter keeps running underneath. Counting is implemented for three modes: one-shot terminal-count signalling, periodic rate pulses and square-wave generation. The other mode codes and the decimal flag are accepted and stored, but the counter holds still under them.

Top module: `pit3_timer`

## Requirements
- R1: Bus addresses 0, 1 and 2 write and read the data port of channels 0, 1 and 2; address 3 is the control port. In a control byte, bits [7:6] select the channel (00, 01, 10), and a control byte with bits [7:6] = 11 changes no channel.
- R2: With access field (control bits [5:4]) = 01, one data write loads the count as {8'h00, byte}, and every read returns the low byte.
- R3: With access field = 10, one data write loads the count as {byte, 8'h00}, and every read returns the high byte.
- R4: With access field = 11, data writes and reads alternate low byte then high byte on one per-channel pointer, and the count loads when the high byte arrives. Any control write to the channel returns the pointer to the low byte.
- R5: A control byte with access field 00 is a snapshot command. It copies the channel's count into a hold register, and reads return the held value while the counter keeps running.
- R6: A held value stays frozen until it has been fully read under the channel's access style (two reads for access 11, one otherwise), and reads then return the live count. A snapshot command issued while a value is held is ignored. A snapshot command leaves the stored mode and access style unchanged.
- R7: Mode 0 (control bits [3:1] = 000): a control write or a completed count load drives the output low. The output goes high on the tick that brings the count from 1 to 0, and it stays high while the count keeps wrapping.
- R8: The count only moves on a tick: a clock edge with the channel's clock-enable and gate both high, after a count has been loaded since the last control write.
- R9: Mode 2 (010): the output is high after a load. It goes low on the tick that brings the count to 1, and on the next tick the count reloads and the output returns high.
- R10: Mode 3 (011): the count steps down by 2 per tick from the loaded value with bit 0 cleared. When it has reached 2, the next tick reloads it and toggles the output, so a count N gives N/2 ticks per half period. The output starts high after a load.
- R11: A loaded count of 0 acts as 65536: the first tick takes it to 16'hFFFF.
- R12: When a snapshot command and a tick fall on the same edge, the held value is the count from before that tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 2 | Register address: 0..2 channel data, 3 control |
| bus_wdata | input | 8 | Write data byte |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_rd | input | 1 | Read strobe, advances byte pointer and hold state |
| bus_rdata | output | 8 | Read data for the addressed port (combinational) |
| chan_ce | input | 3 | Per-channel count enable |
| chan_gate | input | 3 | Per-channel gate; counting needs it high |
| chan_out | output | 3 | Per-channel timer output |

## Verification
A snapshot command and a count decrement can land on the same clock edge. The hold register must then catch the count from before the edge, while the live count moves on. The bench provokes this by raising the channel's clock-enable in the very cycle that the snapshot byte is written. It then reads the held word, which must be the pre-tick value, and reads once more to get the live word, which must be one lower.

// File: rtl/pit_pkg.sv
package pit_pkg;
    localparam int CNT_W  = 16;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        ACC_SNAP = 2'b00,
        ACC_LO   = 2'b01,
        ACC_HI   = 2'b10,
        ACC_WORD = 2'b11
    } acc_e;

    localparam logic [2:0] MODE_TC   = 3'd0;
    localparam logic [2:0] MODE_RATE = 3'd2;
    localparam logic [2:0] MODE_SQ   = 3'd3;

    typedef struct packed {
        acc_e              acc;
        logic [2:0]        mode;
        logic              bcd;
        logic              ptr;
        logic              armed;
        logic [BYTE_W-1:0] stage;
        logic [CNT_W-1:0]  reload;
        logic [CNT_W-1:0]  count;
        logic              held;
        logic [CNT_W-1:0]  hold_val;
        logic              out;
    } chan_st_t;
endpackage

// File: rtl/pit_bus_decode.sv
module pit_bus_decode #(
    parameter int NCH    = 3,
    parameter int ADDR_W = 2
) (
    input  logic              wr,
    input  logic              rd,
    input  logic [ADDR_W-1:0] addr,
    input  logic [3:0]        ctl_hi,
    output logic [NCH-1:0]    cfg_wr,
    output logic [NCH-1:0]    snap,
    output logic [NCH-1:0]    data_wr,
    output logic [NCH-1:0]    data_rd
);
    localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(NCH);

    logic ctrl_hit;
    assign ctrl_hit = wr && (addr == CTRL_ADDR);

    for (genvar i = 0; i < NCH; i++) begin : g_dec
        logic sel_hit;
        assign sel_hit    = ctrl_hit && (ctl_hi[3:2] == 2'(i));
        assign cfg_wr[i]  = sel_hit && (ctl_hi[1:0] != 2'b00);
        assign snap[i]    = sel_hit && (ctl_hi[1:0] == 2'b00);
        assign data_wr[i] = wr && (addr == ADDR_W'(i));
        assign data_rd[i] = rd && (addr == ADDR_W'(i));
    end
endmodule

// File: rtl/pit_channel.sv
module pit_channel
    import pit_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic              snap,
    input  logic [1:0]        cfg_acc,
    input  logic [2:0]        cfg_mode,
    input  logic              cfg_bcd,
    input  logic              data_wr,
    input  logic              data_rd,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              ce,
    input  logic              gate,
    output logic [BYTE_W-1:0] rdata,
    output logic              out
);
    chan_st_t st_d, st_q;
    logic             tick;
    logic             load_done;
    logic [CNT_W-1:0] new_cnt;
    logic [CNT_W-1:0] view;
    logic [CNT_W-1:0] rate_nxt;

    always_comb begin
        st_d      = st_q;
        load_done = 1'b0;
        new_cnt   = '0;
        tick      = st_q.armed && ce && gate;
        rate_nxt  = (st_q.count == CNT_W'(1)) ? st_q.reload : st_q.count - CNT_W'(1);

        if (tick) begin
            unique case (st_q.mode)
                MODE_TC: begin
                    st_d.count = st_q.count - CNT_W'(1);
                    if (st_q.count == CNT_W'(1)) st_d.out = 1'b1;
                end
                MODE_RATE: begin
                    st_d.count = rate_nxt;
                    st_d.out   = (rate_nxt != CNT_W'(1));
                end
                MODE_SQ: begin
                    if (st_q.count == CNT_W'(2)) begin
                        st_d.count = st_q.reload & ~CNT_W'(1);
                        st_d.out   = ~st_q.out;
                    end else begin
                        st_d.count = st_q.count - CNT_W'(2);
                    end
                end
                default: ;
            endcase
        end

        if (snap && !st_q.held) begin
            st_d.held     = 1'b1;
            st_d.hold_val = st_q.count;
        end

        if (data_wr) begin
            unique case (st_q.acc)
                ACC_LO: begin new_cnt = {8'h00, wdata}; load_done = 1'b1; end
                ACC_HI: begin new_cnt = {wdata, 8'h00}; load_done = 1'b1; end
                ACC_WORD: begin
                    if (!st_q.ptr) begin
                        st_d.stage = wdata;
                        st_d.ptr   = 1'b1;
                    end else begin
                        new_cnt   = {wdata, st_q.stage};
                        st_d.ptr  = 1'b0;
                        load_done = 1'b1;
                    end
                end
                default: ;
            endcase
            if (load_done) begin
                st_d.reload = new_cnt;
                st_d.armed  = 1'b1;
                st_d.count  = (st_q.mode == MODE_SQ) ? (new_cnt & ~CNT_W'(1)) : new_cnt;
                st_d.out    = (st_q.mode != MODE_TC);
            end
        end

        if (data_rd) begin
            if (st_q.acc == ACC_WORD) st_d.ptr = ~st_q.ptr;
            if (st_q.acc != ACC_WORD || st_q.ptr) st_d.held = 1'b0;
        end

        if (cfg_wr) begin
            st_d.acc   = acc_e'(cfg_acc);
            st_d.mode  = cfg_mode;
            st_d.bcd   = cfg_bcd;
            st_d.ptr   = 1'b0;
            st_d.armed = 1'b0;
            st_d.count = st_q.count;
            st_d.out   = (cfg_mode != MODE_TC);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.acc <= ACC_WORD;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        view = st_q.held ? st_q.hold_val : st_q.count;
        unique case (st_q.acc)
            ACC_HI:   rdata = view[15:8];
            ACC_WORD: rdata = st_q.ptr ? view[15:8] : view[7:0];
            default:  rdata = view[7:0];
        endcase
    end

    assign out = st_q.out;

    // R7
    mode0_out_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == MODE_TC && st_q.out && !cfg_wr && !data_wr) |=> st_q.out);

    // R8
    no_tick_no_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(ce && gate) && !data_wr) |=> $stable(st_q.count));

    // R6
    hold_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.held && !data_rd) |=> (st_q.held && $stable(st_q.hold_val)));

    // R4
    ptr_word_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.acc != ACC_WORD) |-> !st_q.ptr);
endmodule

// File: rtl/pit3_timer.sv
module pit3_timer
    import pit_pkg::*;
#(
    parameter int NCH    = 3,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [7:0]        bus_rdata,
    input  logic [NCH-1:0]    chan_ce,
    input  logic [NCH-1:0]    chan_gate,
    output logic [NCH-1:0]    chan_out
);
    logic [NCH-1:0] cfg_wr_v, snap_v, data_wr_v, data_rd_v;
    logic [7:0]     ch_rdata [NCH];

    pit_bus_decode #(.NCH(NCH), .ADDR_W(ADDR_W)) u_dec (
        .wr      (bus_wr),
        .rd      (bus_rd),
        .addr    (bus_addr),
        .ctl_hi  (bus_wdata[7:4]),
        .cfg_wr  (cfg_wr_v),
        .snap    (snap_v),
        .data_wr (data_wr_v),
        .data_rd (data_rd_v)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        pit_channel u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .cfg_wr   (cfg_wr_v[i]),
            .snap     (snap_v[i]),
            .cfg_acc  (bus_wdata[5:4]),
            .cfg_mode (bus_wdata[3:1]),
            .cfg_bcd  (bus_wdata[0]),
            .data_wr  (data_wr_v[i]),
            .data_rd  (data_rd_v[i]),
            .wdata    (bus_wdata),
            .ce       (chan_ce[i]),
            .gate     (chan_gate[i]),
            .rdata    (ch_rdata[i]),
            .out      (chan_out[i])
        );
    end

    always_comb begin
        bus_rdata = 8'h00;
        for (int i = 0; i < NCH; i++) begin
            if (bus_addr == ADDR_W'(i)) bus_rdata = ch_rdata[i];
        end
    end

    // R1
    one_ctrl_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cfg_wr_v | snap_v));
endmodule

// File: tb/tb_pit3_timer.sv
`timescale 1ns/1ps
module tb_pit3_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_rdata;
    logic [2:0] chan_ce = '0, chan_gate = 3'b111;
    logic [2:0] chan_out;

    int tests = 0, fails = 0;
    bit done = 1'b0;

    pit3_timer dut (.*);

    always #10 clk = ~clk;

    // {ctrl, first byte, second byte, expected 16-bit count}
    localparam logic [39:0] VEC [5] = '{
        {8'h10, 8'hA5, 8'h00, 16'h00A5},
        {8'h60, 8'h5A, 8'h00, 16'h5A00},
        {8'hB0, 8'h34, 8'h12, 16'h1234},
        {8'h30, 8'hCD, 8'hAB, 16'hABCD},
        {8'h50, 8'h7E, 8'h00, 16'h007E}
    };

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic rd16(logic [1:0] a, output logic [15:0] v);
        logic [7:0] lo, hi;
        rd(a, lo);
        rd(a, hi);
        v = {hi, lo};
    endtask

    task automatic ticks(int ch, int k);
        @(negedge clk);
        chan_ce[ch] = 1'b1;
        repeat (k) @(negedge clk);
        chan_ce[ch] = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0]  b;
        logic [15:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // reset state
        check("R7 reset outputs low", 16'(chan_out), 16'h0);
        rd(2'd0, b);
        check("R4 reset count read", 16'(b), 16'h0);

        // vector table: access styles and address map
        for (int i = 0; i < 5; i++) begin
            logic [7:0]  c;
            logic [1:0]  ch;
            c  = VEC[i][39:32];
            ch = c[7:6];
            wr(2'd3, c);
            wr(ch, VEC[i][31:24]);
            if (c[5:4] == 2'b11) wr(ch, VEC[i][23:16]);
            rd(ch, b);
            if (c[5:4] == 2'b10) check("R3 high-only read", 16'(b), 16'(VEC[i][15:8]));
            else                 check("R2 low/word first read", 16'(b), 16'(VEC[i][7:0]));
            wr(2'd3, {ch, 6'b110000});
            rd16(ch, v);
            check("R1 R2 R3 R4 loaded count", v, VEC[i][15:0]);
        end

        // pointer reset by control write
        wr(2'd3, 8'hB0);
        wr(2'd2, 8'h11);
        wr(2'd3, 8'hB0);
        wr(2'd2, 8'h22);
        wr(2'd2, 8'h33);
        wr(2'd3, 8'hB0);
        rd16(2'd2, v);
        check("R4 pointer reset", v, 16'h3322);

        // mode 0 terminal count
        wr(2'd3, 8'h30);
        check("R7 low after control", 16'(chan_out[0]), 16'h0);
        wr(2'd0, 8'h05);
        wr(2'd0, 8'h00);
        check("R7 low after load", 16'(chan_out[0]), 16'h0);
        ticks(0, 4);
        check("R7 low before terminal", 16'(chan_out[0]), 16'h0);
        ticks(0, 1);
        check("R7 high at terminal", 16'(chan_out[0]), 16'h1);
        ticks(0, 3);
        check("R7 stays high", 16'(chan_out[0]), 16'h1);
        wr(2'd3, 8'h00);
        rd16(2'd0, v);
        check("R7 wrapped count", v, 16'hFFFD);

        // select 11 ignored
        wr(2'd3, 8'hF0);
        check("R1 select 11 ignored out", 16'(chan_out), 16'h1);
        rd16(2'd0, v);
        check("R1 select 11 ignored count", v, 16'hFFFD);

        // zero count is 65536
        wr(2'd3, 8'h30);
        wr(2'd0, 8'h00);
        wr(2'd0, 8'h00);
        ticks(0, 1);
        wr(2'd3, 8'h00);
        rd16(2'd0, v);
        check("R11 zero count wraps", v, 16'hFFFF);
        check("R11 no terminal yet", 16'(chan_out[0]), 16'h0);

        // gate low blocks counting
        wr(2'd3, 8'h30);
        wr(2'd0, 8'h10);
        wr(2'd0, 8'h00);
        chan_gate[0] = 1'b0;
        ticks(0, 5);
        rd16(2'd0, v);
        check("R8 gate low holds", v, 16'h0010);
        chan_gate[0] = 1'b1;
        ticks(0, 2);
        rd16(2'd0, v);
        check("R8 gate high counts", v, 16'h000E);

        // snapshot behaviour
        wr(2'd3, 8'h70);
        wr(2'd1, 8'h20);
        wr(2'd1, 8'h00);
        wr(2'd3, 8'h40);
        ticks(1, 3);
        rd16(2'd1, v);
        check("R5 held value", v, 16'h0020);
        rd16(2'd1, v);
        check("R5 live count kept running", v, 16'h001D);
        wr(2'd3, 8'h40);
        ticks(1, 2);
        wr(2'd3, 8'h40);
        rd16(2'd1, v);
        check("R6 second snapshot ignored", v, 16'h001D);
        rd16(2'd1, v);
        check("R6 live after full read", v, 16'h001B);

        // snapshot on the same edge as a tick
        wr(2'd3, 8'h30);
        wr(2'd0, 8'h00);
        wr(2'd0, 8'h01);
        @(negedge clk);
        bus_addr = 2'd3; bus_wdata = 8'h00; bus_wr = 1'b1; chan_ce[0] = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; chan_ce[0] = 1'b0;
        rd16(2'd0, v);
        check("R12 pre-tick value held", v, 16'h0100);
        rd16(2'd0, v);
        check("R12 live decremented", v, 16'h00FF);

        // mode 2 rate pulses
        wr(2'd3, 8'h74);
        wr(2'd1, 8'h04);
        wr(2'd1, 8'h00);
        check("R9 high after load", 16'(chan_out[1]), 16'h1);
        ticks(1, 2);
        check("R9 high mid count", 16'(chan_out[1]), 16'h1);
        ticks(1, 1);
        check("R9 low at count 1", 16'(chan_out[1]), 16'h0);
        ticks(1, 1);
        check("R9 high after reload", 16'(chan_out[1]), 16'h1);
        ticks(1, 3);
        check("R9 periodic low", 16'(chan_out[1]), 16'h0);

        // mode 3 square wave
        wr(2'd3, 8'hB6);
        wr(2'd2, 8'h06);
        wr(2'd2, 8'h00);
        check("R10 high after load", 16'(chan_out[2]), 16'h1);
        ticks(2, 2);
        check("R10 still high", 16'(chan_out[2]), 16'h1);
        ticks(2, 1);
        check("R10 low half period", 16'(chan_out[2]), 16'h0);
        ticks(2, 3);
        check("R10 high full period", 16'(chan_out[2]), 16'h1);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule